// File: doc/BRIEF.md
# Eight-Channel Low-Side Driver Mode Controller

This block decides, on every clock, whether each of eight low-side driver channels has its gate switched on and whether its open-load diagnostic current source is enabled. Each channel holds a 2-bit mode. A parallel 16-bit command word, qualified by a one-cycle write strobe, loads all eight modes at once. The serial front end that assembles that word is a separate block, and so are the analog sensing and the overload filter.

The block also handles the chip-level controls. These are an enable pin, separate power-on-reset flags for the digital and analog supplies, and a limp-home input that hands four channels directly to their input pins. For each channel the block records whether it reached the off state by power-up or by command. Diagnostic current in the off state stays disabled until a command has touched that channel. This lets a board power up with LED loads and keep them dark.

Top module: `drv_mode_ctrl`

## Requirements
- R1: Channel n (0..7) takes its mode from command bits [2n+1:2n]. Mode 2'b10 drives the gate on with diagnostic current off. Mode 2'b00 (standby) keeps the gate off with diagnostic current off.
- R2: Mode 2'b01 makes the channel's gate follow its direct input pin `din_i[n]`, with diagnostic current off.
- R3: After `rst_n` or any reset event, every mode is 2'b11. In that state every gate and every diagnostic current is off, `diag_armed_o` is all zero, and `fresh_o` is 1.
- R4: A channel in mode 2'b11 reached through an accepted command has its diagnostic current enabled, and its `diag_armed_o` bit reads 1. A channel in 2'b11 from reset keeps diagnostic current disabled.
- R5: In the cycle `en_i` is first seen high after being low, all outputs are off. From the next cycle the state equals the R3 defaults.
- R6: With `en_i` and `lhi_i` both low, all gates and diagnostic currents are off and `lowq_o` is 1. Otherwise `lowq_o` is 0.
- R7: With `lhi_i` high, channels 0..3 drive their gates from `din_i[3:0]`, and channels 4..7 are off. No diagnostic current is enabled. This holds whatever the level of `en_i`.
- R8: Outside limp-home, `por_dig_i` high turns every output off and resets the state. In limp-home it has no effect.
- R9: `por_ana_i` high turns every output off and resets the state in every mode.
- R10: A command write while `en_i` is low or `lhi_i` is high leaves the modes, `diag_armed_o` and `fresh_o` unchanged.
- R11: `fresh_o` is set by every reset and cleared by the first accepted command write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Device enable pin level |
| lhi_i | input | 1 | Limp-home request |
| por_dig_i | input | 1 | Digital supply power-on-reset flag |
| por_ana_i | input | 1 | Analog supply power-on-reset flag |
| cmd_wr_i | input | 1 | One-cycle command word strobe |
| cmd_word_i | input | 16 | Eight packed 2-bit channel modes |
| din_i | input | 8 | Direct channel input pins |
| gate_on_o | output | 8 | Per-channel gate drive |
| diag_en_o | output | 8 | Per-channel open-load diagnostic current enable |
| diag_armed_o | output | 8 | Channel's off state came from a command, not power-up |
| lowq_o | output | 1 | Low-quiescent state indicator |
| fresh_o | output | 1 | Set by reset, cleared by the first accepted command |

## Verification
The assertions check these relations on every cycle: the low-quiescent outputs, limp-home silencing of the upper channels, diagnostic current only on armed channels, the effect of an analog-supply or enable-edge reset, and the freezing of state under a rejected write. Only the bench scenarios can show the remaining behaviour. This covers the per-mode decode with bit positions, follow-mode tracking of changing input pins, limp-home mapping of the lower channels, and the digital-supply flag being ignored in limp-home. It also covers the loss of arming that the next enable edge causes.

// File: rtl/drv_mode_pkg.sv
package drv_mode_pkg;
    typedef enum logic [1:0] {
        MODE_STBY   = 2'b00,
        MODE_FOLLOW = 2'b01,
        MODE_ON     = 2'b10,
        MODE_OFF    = 2'b11
    } mode_e;
endpackage

// File: rtl/drv_supervisor.sv
module drv_supervisor (
    input  logic en_i,
    input  logic en_prev_i,
    input  logic lhi_i,
    input  logic por_dig_i,
    input  logic por_ana_i,
    input  logic cmd_wr_i,
    output logic reset_evt_o,
    output logic force_off_o,
    output logic cmd_take_o,
    output logic lowq_o
);
    logic en_rise;
    logic por_hit;

    always_comb begin
        en_rise     = en_i & ~en_prev_i;
        // digital supply flag is masked while limp-home holds the part
        por_hit     = por_ana_i | (por_dig_i & ~lhi_i);
        reset_evt_o = por_hit | en_rise;
        lowq_o      = ~en_i & ~lhi_i;
        force_off_o = reset_evt_o | lowq_o | (~lhi_i & ~en_i);
        cmd_take_o  = cmd_wr_i & en_i & ~lhi_i & ~reset_evt_o;
    end
endmodule

// File: rtl/drv_ch_out.sv
module drv_ch_out
    import drv_mode_pkg::*;
#(
    parameter bit LIMP_FOLLOW = 1'b1
) (
    input  logic [1:0] mode_i,
    input  logic       pu_off_i,
    input  logic       limp_i,
    input  logic       force_off_i,
    input  logic       din_i,
    output logic       gate_o,
    output logic       diag_o
);
    mode_e mode;

    always_comb begin
        mode   = mode_e'(mode_i);
        gate_o = 1'b0;
        diag_o = 1'b0;
        if (force_off_i) begin
            gate_o = 1'b0;
            diag_o = 1'b0;
        end else if (limp_i) begin
            gate_o = LIMP_FOLLOW ? din_i : 1'b0;
        end else begin
            unique case (mode)
                MODE_STBY:   gate_o = 1'b0;
                MODE_FOLLOW: gate_o = din_i;
                MODE_ON:     gate_o = 1'b1;
                MODE_OFF:    diag_o = ~pu_off_i;
                default:     gate_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/drv_mode_ctrl.sv
module drv_mode_ctrl
    import drv_mode_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int LIMP_CH = 4,
    parameter int MODE_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_i,
    input  logic                     lhi_i,
    input  logic                     por_dig_i,
    input  logic                     por_ana_i,
    input  logic                     cmd_wr_i,
    input  logic [NUM_CH*MODE_W-1:0] cmd_word_i,
    input  logic [NUM_CH-1:0]        din_i,
    output logic [NUM_CH-1:0]        gate_on_o,
    output logic [NUM_CH-1:0]        diag_en_o,
    output logic [NUM_CH-1:0]        diag_armed_o,
    output logic                     lowq_o,
    output logic                     fresh_o
);
    localparam int CMD_W = NUM_CH * MODE_W;

    typedef struct packed {
        logic [NUM_CH-1:0][MODE_W-1:0] mode;
        logic [NUM_CH-1:0]             pu_off;
        logic                          fresh;
        logic                          en_prev;
    } state_t;

    state_t st_d, st_q;
    logic   reset_evt, force_off, cmd_take;

    drv_supervisor u_sup (
        .en_i        (en_i),
        .en_prev_i   (st_q.en_prev),
        .lhi_i       (lhi_i),
        .por_dig_i   (por_dig_i),
        .por_ana_i   (por_ana_i),
        .cmd_wr_i    (cmd_wr_i),
        .reset_evt_o (reset_evt),
        .force_off_o (force_off),
        .cmd_take_o  (cmd_take),
        .lowq_o      (lowq_o)
    );

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = en_i;
        if (reset_evt) begin
            for (int c = 0; c < NUM_CH; c++) st_d.mode[c] = MODE_OFF;
            st_d.pu_off = '1;
            st_d.fresh  = 1'b1;
        end else if (cmd_take) begin
            for (int c = 0; c < NUM_CH; c++)
                st_d.mode[c] = cmd_word_i[c*MODE_W +: MODE_W];
            st_d.pu_off = '0;
            st_d.fresh  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) st_q.mode[c] <= MODE_OFF;
            st_q.pu_off  <= '1;
            st_q.fresh   <= 1'b1;
            st_q.en_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        drv_ch_out #(.LIMP_FOLLOW(g < LIMP_CH)) u_ch (
            .mode_i      (st_q.mode[g]),
            .pu_off_i    (st_q.pu_off[g]),
            .limp_i      (lhi_i),
            .force_off_i (force_off),
            .din_i       (din_i[g]),
            .gate_o      (gate_on_o[g]),
            .diag_o      (diag_en_o[g])
        );
    end

    assign diag_armed_o = ~st_q.pu_off;
    assign fresh_o      = st_q.fresh;

    logic unused_w;
    assign unused_w = ^CMD_W;
endmodule

// File: rtl/drv_mode_ctrl_chk.sv
module drv_mode_ctrl_chk #(
    parameter int NUM_CH  = 8,
    parameter int LIMP_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              lhi_i,
    input logic              por_dig_i,
    input logic              por_ana_i,
    input logic              cmd_wr_i,
    input logic [NUM_CH-1:0] gate_on_o,
    input logic [NUM_CH-1:0] diag_en_o,
    input logic [NUM_CH-1:0] diag_armed_o,
    input logic              lowq_o,
    input logic              fresh_o
);
    // R6
    lowq_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !lhi_i) |-> (gate_on_o == '0 && diag_en_o == '0 && lowq_o));

    // R7
    limp_upper_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lhi_i |-> (gate_on_o[NUM_CH-1:LIMP_CH] == '0 && diag_en_o == '0));

    // R4
    diag_only_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_en_o & ~diag_armed_o) == '0);

    // R9
    ana_por_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_ana_i |-> (gate_on_o == '0 && diag_en_o == '0) ##1 (diag_armed_o == '0 && fresh_o));

    // R5
    en_edge_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_i) |=> (diag_armed_o == '0 && fresh_o));

    // R10
    rejected_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && (!en_i || lhi_i) && !por_ana_i && !(por_dig_i && !lhi_i) && !$rose(en_i))
        |=> ($stable(diag_armed_o) && $stable(fresh_o)));
endmodule

bind drv_mode_ctrl drv_mode_ctrl_chk #(.NUM_CH(NUM_CH), .LIMP_CH(LIMP_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .lhi_i        (lhi_i),
    .por_dig_i    (por_dig_i),
    .por_ana_i    (por_ana_i),
    .cmd_wr_i     (cmd_wr_i),
    .gate_on_o    (gate_on_o),
    .diag_en_o    (diag_en_o),
    .diag_armed_o (diag_armed_o),
    .lowq_o       (lowq_o),
    .fresh_o      (fresh_o)
);

// File: tb/tb_drv_mode_ctrl.sv
module tb_drv_mode_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0, lhi_i = 1'b0, por_dig_i = 1'b0, por_ana_i = 1'b0, cmd_wr_i = 1'b0;
    logic [15:0] cmd_word_i = '0;
    logic [7:0]  din_i = '0;
    logic [7:0]  gate_on_o, diag_en_o, diag_armed_o;
    logic        lowq_o, fresh_o;

    int checks = 0;
    int errors = 0;

    // reference state, held as plain integers and bits
    int  m_mode [8];
    bit  m_pu   [8];
    bit  m_fresh;
    bit  m_enp;

    always #5 clk = ~clk;

    drv_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .lhi_i(lhi_i),
        .por_dig_i(por_dig_i), .por_ana_i(por_ana_i), .cmd_wr_i(cmd_wr_i),
        .cmd_word_i(cmd_word_i), .din_i(din_i), .gate_on_o(gate_on_o),
        .diag_en_o(diag_en_o), .diag_armed_o(diag_armed_o), .lowq_o(lowq_o),
        .fresh_o(fresh_o)
    );

    task automatic model_defaults();
        for (int c = 0; c < 8; c++) begin m_mode[c] = 3; m_pu[c] = 1'b1; end
        m_fresh = 1'b1;
    endtask

    task automatic compare(input string tag);
        logic [7:0] eg, ed, ea;
        bit force_off;
        force_off = por_ana_i | (!lhi_i & (por_dig_i | !en_i)) | (en_i & !m_enp);
        for (int c = 0; c < 8; c++) begin
            eg[c] = 1'b0; ed[c] = 1'b0; ea[c] = !m_pu[c];
            if (!force_off) begin
                if (lhi_i) eg[c] = (c < 4) ? din_i[c] : 1'b0;
                else if (m_mode[c] == 1) eg[c] = din_i[c];
                else if (m_mode[c] == 2) eg[c] = 1'b1;
                else if (m_mode[c] == 3) ed[c] = !m_pu[c];
            end
        end
        checks++;
        if (gate_on_o !== eg || diag_en_o !== ed || diag_armed_o !== ea ||
            lowq_o !== (!en_i && !lhi_i) || fresh_o !== m_fresh) begin
            errors++;
            $display("FAIL %s: gate=%h/%h diag=%h/%h armed=%h/%h lowq=%b/%b fresh=%b/%b",
                     tag, gate_on_o, eg, diag_en_o, ed, diag_armed_o, ea,
                     lowq_o, !en_i && !lhi_i, fresh_o, m_fresh);
        end
    endtask

    task automatic step(input bit en, input bit lhi, input bit pd, input bit pa,
                        input bit wr, input logic [15:0] word, input logic [7:0] din,
                        input string tag);
        @(negedge clk);
        en_i = en; lhi_i = lhi; por_dig_i = pd; por_ana_i = pa;
        cmd_wr_i = wr; cmd_word_i = word; din_i = din;
        #1 compare(tag);
        @(posedge clk);
        if (pa || (pd && !lhi) || (en && !m_enp)) model_defaults();
        else if (wr && en && !lhi) begin
            for (int c = 0; c < 8; c++) begin
                m_mode[c] = int'(word[2*c +: 2]);
                m_pu[c] = 1'b0;
            end
            m_fresh = 1'b0;
        end
        m_enp = en;
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_defaults();
        m_enp = 1'b0;
        #22 rst_n = 1'b1;
        // R3 reset state, R6 low-quiescent
        step(0, 0, 0, 0, 0, 16'h0000, 8'hFF, "R3");
        step(0, 0, 0, 0, 0, 16'h0000, 8'h00, "R6");
        // R5 enable edge
        step(1, 0, 0, 0, 0, 16'h0000, 8'hFF, "R5");
        step(1, 0, 0, 0, 0, 16'h0000, 8'hFF, "R3");
        // R1 R2 mixed modes: ch0=10 ch1=01 ch2=00 ch3=11 ch4=10 ch5=01 ch6=11 ch7=00
        step(1, 0, 0, 0, 1, 16'b00_11_01_10_11_00_01_10, 8'h00, "R11");
        step(1, 0, 0, 0, 0, 16'h0000, 8'h00, "R1");
        step(1, 0, 0, 0, 0, 16'h0000, 8'hFF, "R2");
        step(1, 0, 0, 0, 0, 16'h0000, 8'h22, "R2");
        // R4 all commanded off
        step(1, 0, 0, 0, 1, 16'hFFFF, 8'h00, "R4");
        step(1, 0, 0, 0, 0, 16'h0000, 8'h00, "R4");
        // R10 write with enable low ignored
        step(0, 0, 0, 0, 1, 16'hAAAA, 8'h00, "R10");
        step(0, 0, 0, 0, 0, 16'h0000, 8'h00, "R10");
        step(1, 0, 0, 0, 0, 16'h0000, 8'h00, "R5");
        step(1, 0, 0, 0, 1, 16'hAAAA, 8'h00, "R1");
        // R7 limp-home with enable high and low, R10 under limp-home
        step(1, 1, 0, 0, 1, 16'h5555, 8'hA5, "R7");
        step(0, 1, 0, 0, 0, 16'h0000, 8'h5A, "R7");
        // R8 digital flag ignored in limp-home
        step(0, 1, 1, 0, 0, 16'h0000, 8'h0F, "R8");
        step(0, 1, 0, 0, 0, 16'h0000, 8'h0C, "R8");
        step(1, 1, 0, 0, 0, 16'h0000, 8'h03, "R7");
        step(1, 0, 0, 0, 0, 16'h0000, 8'h00, "R10");
        // R9 analog flag in limp-home
        step(1, 1, 0, 1, 0, 16'h0000, 8'h0F, "R9");
        step(1, 1, 0, 0, 0, 16'h0000, 8'h0F, "R9");
        step(1, 0, 0, 0, 1, 16'hAAAA, 8'h00, "R1");
        // R8 digital flag outside limp-home
        step(1, 0, 1, 0, 0, 16'h0000, 8'h00, "R8");
        step(1, 0, 0, 0, 0, 16'h0000, 8'h00, "R8");
        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 8) != 0, ($urandom % 6) == 0, ($urandom % 20) == 0,
                 ($urandom % 25) == 0, ($urandom % 3) == 0, 16'($urandom),
                 8'($urandom), "R1");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule